// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the digital control engine of a serially controlled successive-approximation converter. It watches a slave I/O clock, counts its falling edges, opens a sampling window once four edges have been seen and closes it after 8, 12 or 16 edges, depending on a 2-bit length field. Closing the window drops the end-of-conversion flag and starts a modelled conversion. That conversion lasts a fixed number of system-clock cycles. When it finishes, the value on the conversion input is latched into the result register, the end-of-conversion flag rises again and a new I/O cycle starts at once.

An active-low chip select gates the whole block. Both the I/O clock and the chip select are brought into the system clock domain through two-flop synchronizers, and the chip select is also debounced. After a debounced release the block is frozen, so I/O clock edges have no effect. A debounced reassertion resets the block, abandons any conversion that is under way and keeps the previous result. Edge counting then resumes only after the I/O clock has stayed low for a minimum idle time. A start-of-output strobe marks the points where the first result bit would be presented.

Top module: `serial_adc_seq`

## Requirements
- R1: While reset is applied, `eoc` is 1 and `sampling`, `result_latch` and `out_start` are 0.
- R2: `sampling` is 0 until the fourth counted falling edge of the I/O clock in a cycle and is 1 from that edge until the window closes.
- R3: The length field is captured at the fourth counted edge. Value 2'b01 selects 8 edges, 2'b00 and 2'b10 select 12 edges and 2'b11 selects 16 edges. At the selected edge `eoc` and `sampling` both drop to 0. Later changes of the field do not affect the current cycle.
- R4: `eoc` stays low for exactly CONV_CYC system-clock cycles. It then rises in the same cycle that `result_latch` pulses and `result_q` takes the value of `conv_value`. `result_q` changes at no other time.
- R5: I/O clock edges that occur during a conversion are ignored. The cycle that follows a completed conversion starts its edge count from zero.
- R6: `out_start` pulses for one cycle when a conversion completes while the chip is selected, and in the cycle in which a debounced chip-select assertion takes effect.
- R7: After `cs_n` has been high for the debounce time, the block is frozen: I/O clock edges are ignored, and `eoc`, `sampling` and any conversion in progress hold their state.
- R8: A debounced chip-select assertion resets the block: `eoc` becomes 1 and `sampling` becomes 0. An interrupted conversion produces no `result_latch`, and `result_q` keeps its previous value.
- R9: After a chip-select reset, edges are counted only once the synchronized I/O clock has been low for IDLE_CYC consecutive cycles. Edges that arrive before then are not counted.
- R10: An I/O clock falling edge that is detected in the same cycle in which a conversion completes is not counted toward the new cycle.
- R11: A high pulse on `cs_n` shorter than the debounce time neither freezes nor resets the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| io_clk | input | 1 | Slave I/O clock, asynchronous |
| len_sel | input | 2 | Data-length field |
| conv_value | input | RES_W | Result of the modelled conversion |
| eoc | output | 1 | End-of-conversion flag, high when idle |
| sampling | output | 1 | Sampling window open |
| result_latch | output | 1 | One-cycle strobe: result latched |
| out_start | output | 1 | One-cycle strobe: first output bit presented |
| result_q | output | RES_W | Latched conversion result |

## Verification
Two events can collide in a single cycle: the completion of a conversion and the detection of an I/O clock falling edge. The bench times a falling edge so that, after the three-register synchronizer and edge-detector path, it is detected in exactly the cycle in which the conversion ends. It then checks that `eoc` rises together with the latch strobe and that three further edges leave `sampling` at 0, while the fourth edge sets it. If the colliding edge had been counted, the third edge would already open the window.

// File: rtl/serial_adc_seq_pkg.sv
package serial_adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_COUNT = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;

  localparam int EDGE_W       = 5;
  localparam int SAMPLE_START = 4;

  function automatic logic [EDGE_W-1:0] len_to_edges(input logic [1:0] len);
    case (len)
      2'b01:   len_to_edges = 5'd8;
      2'b11:   len_to_edges = 5'd16;
      default: len_to_edges = 5'd12;
    endcase
  endfunction

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/adc_sync_chain.sv
module adc_sync_chain #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/adc_io_edge.sv
module adc_io_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic io_clk,
  output logic io_lvl,
  output logic io_fall
);
  logic prev_q;

  adc_sync_chain #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (io_clk),
    .q     (io_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= io_lvl;
  end

  assign io_fall = prev_q & ~io_lvl;
endmodule

// File: rtl/adc_cs_debounce.sv
module adc_cs_debounce #(
  parameter int STAGES  = 2,
  parameter int DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic sel,
  output logic sel_rise
);
  localparam int          DW       = $clog2(DEB_CYC + 1);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYC - 1);

  logic          cs_lvl;
  logic          want_sel;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          rise_q, rise_d;

  adc_sync_chain #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cs_n),
    .q     (cs_lvl)
  );

  assign want_sel = ~cs_lvl;

  always_comb begin
    cnt_d  = '0;
    sel_d  = sel_q;
    rise_d = 1'b0;
    if (want_sel != sel_q) begin
      if (cnt_q == DEB_LAST) begin
        sel_d  = want_sel;
        rise_d = want_sel;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      rise_q <= rise_d;
    end
  end

  assign sel      = sel_q;
  assign sel_rise = rise_q;
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import serial_adc_seq_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int IDLE_CYC = 2,
  parameter int CONV_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             sel_rise,
  input  logic             io_lvl,
  input  logic             io_fall,
  input  logic [1:0]       len_sel,
  input  logic [RES_W-1:0] conv_value,
  output logic             eoc,
  output logic             sampling,
  output logic             result_latch,
  output logic             out_start,
  output logic [RES_W-1:0] result_q
);
  localparam int              IW        = $clog2(IDLE_CYC + 1);
  localparam int              CVW       = $clog2(CONV_CYC + 1);
  localparam logic [IW-1:0]   IDLE_LAST = IW'(IDLE_CYC - 1);
  localparam logic [CVW-1:0]  CONV_LAST = CVW'(CONV_CYC - 1);
  localparam logic [EDGE_W-1:0] OPEN_AT = EDGE_W'(SAMPLE_START - 1);

  seq_state_e         state_q, state_d;
  logic [EDGE_W-1:0]  ecnt_q, ecnt_d;
  logic [1:0]         len_q, len_d;
  logic [IW-1:0]      idle_q, idle_d;
  logic [CVW-1:0]     conv_q, conv_d;
  logic               eoc_q, eoc_d;
  logic               samp_q, samp_d;
  logic               latch_q, latch_d;
  logic               ostart_q, ostart_d;
  logic [RES_W-1:0]   res_q, res_d;
  logic [EDGE_W-1:0]  ecnt_inc;
  logic [EDGE_W-1:0]  close_at;

  assign ecnt_inc = ecnt_q + 1'b1;
  assign close_at = len_to_edges(len_q);

  always_comb begin
    state_d  = state_q;
    ecnt_d   = ecnt_q;
    len_d    = len_q;
    idle_d   = idle_q;
    conv_d   = conv_q;
    eoc_d    = eoc_q;
    samp_d   = samp_q;
    latch_d  = 1'b0;
    ostart_d = 1'b0;
    res_d    = res_q;

    if (sel_rise) begin
      state_d  = ST_ARM;
      ecnt_d   = '0;
      idle_d   = '0;
      conv_d   = '0;
      eoc_d    = 1'b1;
      samp_d   = 1'b0;
      ostart_d = 1'b1;
    end else if (sel) begin
      case (state_q)
        ST_ARM: begin
          if (io_lvl) begin
            idle_d = '0;
          end else if (idle_q == IDLE_LAST) begin
            idle_d  = '0;
            state_d = ST_COUNT;
          end else begin
            idle_d = idle_q + 1'b1;
          end
        end
        ST_COUNT: begin
          if (io_fall) begin
            if (ecnt_q == OPEN_AT) begin
              ecnt_d = ecnt_inc;
              len_d  = len_sel;
              samp_d = 1'b1;
            end else if (ecnt_q > OPEN_AT && ecnt_inc == close_at) begin
              ecnt_d  = '0;
              conv_d  = '0;
              eoc_d   = 1'b0;
              samp_d  = 1'b0;
              state_d = ST_CONV;
            end else begin
              ecnt_d = ecnt_inc;
            end
          end
        end
        ST_CONV: begin
          if (conv_q == CONV_LAST) begin
            conv_d   = '0;
            ecnt_d   = '0;
            eoc_d    = 1'b1;
            latch_d  = 1'b1;
            ostart_d = 1'b1;
            res_d    = conv_value;
            state_d  = ST_COUNT;
          end else begin
            conv_d = conv_q + 1'b1;
          end
        end
        default: state_d = ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_ARM;
      ecnt_q   <= '0;
      len_q    <= 2'b00;
      idle_q   <= '0;
      conv_q   <= '0;
      eoc_q    <= 1'b1;
      samp_q   <= 1'b0;
      latch_q  <= 1'b0;
      ostart_q <= 1'b0;
      res_q    <= '0;
    end else begin
      state_q  <= state_d;
      ecnt_q   <= ecnt_d;
      len_q    <= len_d;
      idle_q   <= idle_d;
      conv_q   <= conv_d;
      eoc_q    <= eoc_d;
      samp_q   <= samp_d;
      latch_q  <= latch_d;
      ostart_q <= ostart_d;
      res_q    <= res_d;
    end
  end

  assign eoc          = eoc_q;
  assign sampling     = samp_q;
  assign result_latch = latch_q;
  assign out_start    = ostart_q;
  assign result_q     = res_q;
endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq #(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 4,
  parameter int IDLE_CYC    = 2,
  parameter int CONV_CYC    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             io_clk,
  input  logic [1:0]       len_sel,
  input  logic [RES_W-1:0] conv_value,
  output logic             eoc,
  output logic             sampling,
  output logic             result_latch,
  output logic             out_start,
  output logic [RES_W-1:0] result_q
);
  logic rst_int_n;
  logic io_lvl;
  logic io_fall;
  logic cs_sel;
  logic cs_sel_rise;

  adc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  adc_io_edge #(.STAGES(SYNC_STAGES)) u_io (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .io_clk  (io_clk),
    .io_lvl  (io_lvl),
    .io_fall (io_fall)
  );

  adc_cs_debounce #(.STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)) u_cs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_n     (cs_n),
    .sel      (cs_sel),
    .sel_rise (cs_sel_rise)
  );

  adc_seq_core #(.RES_W(RES_W), .IDLE_CYC(IDLE_CYC), .CONV_CYC(CONV_CYC)) u_core (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sel          (cs_sel),
    .sel_rise     (cs_sel_rise),
    .io_lvl       (io_lvl),
    .io_fall      (io_fall),
    .len_sel      (len_sel),
    .conv_value   (conv_value),
    .eoc          (eoc),
    .sampling     (sampling),
    .result_latch (result_latch),
    .out_start    (out_start),
    .result_q     (result_q)
  );
endmodule

// File: rtl/serial_adc_seq_chk.sv
module serial_adc_seq_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_sel,
  input logic             eoc,
  input logic             sampling,
  input logic             result_latch,
  input logic             out_start,
  input logic [RES_W-1:0] result_q
);
  a_r2_no_sample_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> !sampling);

  a_r4_latch_ends_conv: assert property (@(posedge clk) disable iff (!rst_n)
    result_latch |-> $past(!eoc));

  a_r4_result_only_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_q) |-> result_latch);

  a_r7_frozen_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sel |=> ($stable(eoc) && $stable(sampling) && !result_latch));

  a_r8_eoc_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> (result_latch || out_start));

  a_r6_start_only_idle_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> (eoc && !sampling));
endmodule

bind serial_adc_seq serial_adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_sel       (cs_sel),
  .eoc          (eoc),
  .sampling     (sampling),
  .result_latch (result_latch),
  .out_start    (out_start),
  .result_q     (result_q)
);

// File: tb/serial_adc_seq_bench.sv
module serial_adc_seq_bench;
  localparam int RES_W    = 12;
  localparam int CONV_CYC = 10;

  logic             clk;
  logic             rst_n;
  logic             cs_n;
  logic             io_clk;
  logic [1:0]       len_sel;
  logic [RES_W-1:0] conv_value;
  logic             eoc;
  logic             sampling;
  logic             result_latch;
  logic             out_start;
  logic [RES_W-1:0] result_q;

  int checks = 0;
  int bad = 0;
  int ostart_cnt = 0;
  int latch_cnt = 0;
  bit done = 0;
  logic [RES_W-1:0] exp_q[$];
  logic [RES_W-1:0] last_exp;

  serial_adc_seq u_serial_adc_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .io_clk       (io_clk),
    .len_sel      (len_sel),
    .conv_value   (conv_value),
    .eoc          (eoc),
    .sampling     (sampling),
    .result_latch (result_latch),
    .out_start    (out_start),
    .result_q     (result_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected results as latch strobes appear
  always @(posedge clk) begin
    #3;
    if (rst_n && out_start) ostart_cnt++;
    if (rst_n && result_latch) begin
      latch_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected latch", int'(result_q), -1);
      end else begin
        logic [RES_W-1:0] e;
        e = exp_q.pop_front();
        chk(result_q == e, "R4 latched value", int'(result_q), int'(e));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fall(input int h);
    io_clk = 1'b1; tick(h);
    io_clk = 1'b0; tick(h);
  endtask

  task automatic falls(input int n);
    for (int i = 0; i < n; i++) fall(3);
  endtask

  task automatic expect_conv(input logic [RES_W-1:0] v);
    conv_value = v;
    exp_q.push_back(v);
    last_exp = v;
  endtask

  task automatic wait_eoc_high();
    for (int i = 0; i < 100 && eoc == 1'b0; i++) tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int ost;
    int lowc;
    rst_n = 1'b0; cs_n = 1'b1; io_clk = 1'b0; len_sel = 2'b01; conv_value = '0;
    last_exp = '0;
    tick(3);
    chk(eoc == 1'b1, "R1 eoc in reset", int'(eoc), 1);
    chk(sampling == 1'b0, "R1 sampling in reset", int'(sampling), 0);
    chk(result_latch == 1'b0 && out_start == 1'b0, "R1 strobes in reset",
        int'({result_latch, out_start}), 0);
    rst_n = 1'b1; tick(3);

    // select: debounced assertion gives a start strobe (R6)
    cs_n = 1'b0; tick(12);
    chk(ostart_cnt == 1, "R6 start on select", ostart_cnt, 1);

    // 8-edge cycle (R2, R3, R4, R6)
    len_sel = 2'b01;
    falls(3);
    chk(sampling == 1'b0, "R2 closed after 3 edges", int'(sampling), 0);
    falls(1);
    chk(sampling == 1'b1, "R2 open after 4 edges", int'(sampling), 1);
    falls(3);
    chk(eoc == 1'b1, "R3 len 01 edge 7", int'(eoc), 1);
    expect_conv(12'hA5C);
    falls(1);
    chk(eoc == 1'b0 && sampling == 1'b0, "R3 len 01 closes at 8",
        int'({eoc, sampling}), 0);
    lowc = 0;
    while (eoc == 1'b0 && lowc < 100) begin lowc++; tick(1); end
    chk(lowc == CONV_CYC, "R4 conversion length", lowc, CONV_CYC);
    chk(ostart_cnt == 2, "R6 start on completion", ostart_cnt, 2);
    chk(result_q == 12'hA5C, "R4 result held", int'(result_q), 'hA5C);

    // 12-edge with 00, edges during conversion ignored (R3, R5)
    len_sel = 2'b00;
    falls(11);
    chk(eoc == 1'b1, "R3 len 00 edge 11", int'(eoc), 1);
    expect_conv(12'h3C1);
    falls(1);
    chk(eoc == 1'b0, "R3 len 00 closes at 12", int'(eoc), 0);
    fall(2); fall(2);
    wait_eoc_high();
    falls(3);
    chk(sampling == 1'b0, "R5 conv edges ignored", int'(sampling), 0);
    len_sel = 2'b10;
    falls(1);
    chk(sampling == 1'b1, "R5 fresh count", int'(sampling), 1);
    falls(7);
    chk(eoc == 1'b1, "R3 len 10 edge 11", int'(eoc), 1);
    expect_conv(12'h001);
    falls(1);
    chk(eoc == 1'b0, "R3 len 10 closes at 12", int'(eoc), 0);
    wait_eoc_high();

    // 16 edges, field changed after capture (R3)
    len_sel = 2'b11;
    falls(4);
    len_sel = 2'b01;
    falls(11);
    chk(eoc == 1'b1, "R3 len 11 edge 15", int'(eoc), 1);
    expect_conv(12'hFFE);
    falls(1);
    chk(eoc == 1'b0, "R3 len 11 closes at 16", int'(eoc), 0);
    wait_eoc_high();

    // collision: edge detected in the completing cycle (R10)
    falls(7);
    expect_conv(12'h5A5);
    falls(1);
    chk(eoc == 1'b0, "R10 conversion started", int'(eoc), 0);
    io_clk = 1'b1;
    tick(CONV_CYC - 3);
    io_clk = 1'b0;
    tick(3);
    chk(eoc == 1'b1 && latch_cnt == 5, "R10 completion with edge",
        int'(eoc), 1);
    falls(3);
    chk(sampling == 1'b0, "R10 colliding edge dropped", int'(sampling), 0);
    falls(1);
    chk(sampling == 1'b1, "R10 fourth edge opens", int'(sampling), 1);

    // freeze on release (R7) and reset on reassert (R8, R6)
    falls(1);
    ost = ostart_cnt;
    cs_n = 1'b1; tick(10);
    falls(5);
    chk(eoc == 1'b1 && sampling == 1'b1, "R7 frozen while released",
        int'({eoc, sampling}), 3);
    cs_n = 1'b0; tick(10);
    chk(eoc == 1'b1 && sampling == 1'b0, "R8 reset on reassert",
        int'({eoc, sampling}), 2);
    chk(ostart_cnt == ost + 1, "R6 start on reassert", ostart_cnt, ost + 1);

    // abort a conversion (R7, R8)
    falls(8);
    conv_value = 12'h777;
    chk(eoc == 1'b0, "R8 conversion started", int'(eoc), 0);
    cs_n = 1'b1; tick(20);
    chk(eoc == 1'b0, "R7 conversion frozen", int'(eoc), 0);
    cs_n = 1'b0; tick(10);
    chk(eoc == 1'b1, "R8 eoc after abort", int'(eoc), 1);
    chk(result_q == last_exp, "R8 previous result kept", int'(result_q),
        int'(last_exp));

    // short chip-select glitch (R11)
    falls(4);
    ost = ostart_cnt;
    cs_n = 1'b1; tick(2);
    cs_n = 1'b0; tick(10);
    chk(sampling == 1'b1, "R11 glitch ignored", int'(sampling), 1);
    chk(ostart_cnt == ost, "R11 no reset strobe", ostart_cnt, ost);

    // minimum idle after reset (R9)
    cs_n = 1'b1; tick(10);
    io_clk = 1'b1;
    cs_n = 1'b0; tick(12);
    for (int i = 0; i < 6; i++) begin
      io_clk = 1'b0; tick(1);
      io_clk = 1'b1; tick(2);
    end
    io_clk = 1'b0; tick(5);
    chk(sampling == 1'b0, "R9 short lows not counted", int'(sampling), 0);
    falls(3);
    chk(sampling == 1'b0, "R9 count starts after idle", int'(sampling), 0);
    falls(1);
    chk(sampling == 1'b1, "R9 fourth edge opens", int'(sampling), 1);

    tick(5);
    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule